// File: doc/BRIEF.md
# Parallel NOR Flash Command Controller

This block models the control logic of a byte-wide parallel NOR flash: eight uniform sectors selected by the top three address bits, plus an internal byte array. Bus cycles arrive on active-low chip-enable, write-enable and output-enable strobes and are sampled on the rising clock edge. A write cycle is a clock edge with chip-enable and write-enable low and output-enable high. A read cycle is a clock edge with chip-enable and output-enable low and write-enable high. Read data is registered on that edge.

Write cycles feed an unlock-key command grammar. The grammar starts timed embedded program and erase operations, enters and leaves a two-cycle programming shortcut, and pauses or continues an erase. While an operation runs, reads return a polling status byte instead of array data. Software can also program other sectors while an erase is paused. Per-sector protection inputs and a low-supply inhibit input block changes to the array.

Only address bits 10..0 take part in matching command addresses. Array storage keeps `OFF_W` offset bits per sector, which is 16 bytes per sector by default. Array reset leaves every byte at 0xFF.

Top module: `nor_cmd_ctrl`

## Requirements
- R1: After reset, a read of any address returns 0xFF and no operation is running.
- R2: The writes 0xAA@0x555, 0x55@0x2AA and 0xA0@0x555, followed by datum D at address A, program byte A to (old AND D) after `PGM_CYC` cycles.
- R3: The writes 0xAA@0x555, 0x55@0x2AA and 0x20@0x555 enter bypass mode. In bypass mode, 0xA0 at any address followed by D@A programs the byte. A write of 0xF0 leaves bypass mode.
- R4: While an operation runs, a read returns bit 7 as the complement of bit 7 of the datum being programmed, or 0 during an erase, and returns bits 5..0 as 0.
- R5: While an operation runs, bit 6 inverts between successive reads. Once the operation is done, reads return array data and bit 6 stops changing.
- R6: The writes 0xAA@0x555, 0x55@0x2AA, 0x80@0x555, 0xAA@0x555 and 0x55@0x2AA, followed by 0x30 at any address in sector S, erase S. The erase first writes 0x00 to every byte of S after `PRE_CYC` cycles, then writes 0xFF after `ERS_CYC` more cycles.
- R7: The same five writes followed by 0x10@0x555 erase every unprotected sector.
- R8: A write of 0xB0 during an erase pauses it. While paused, reads of any sector return the current array contents. A write of 0x30 continues the erase, which then completes.
- R9: While an erase is paused, a program to a sector that is not being erased runs to completion and the erase then remains paused. A program to a sector that is being erased is dropped.
- R10: When `prot_i[S]` is high, a program or erase of sector S is dropped and no operation starts. A chip erase skips sector S.
- R11: Write cycles made while `vlow_i` is high have no effect.
- R12: A write that does not fit the expected command sequence returns the grammar to read mode. A write of 0xF0 also returns it to read mode. Writes other than 0xB0 are ignored while an operation runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ce_ni | input | 1 | Chip enable, active low |
| we_ni | input | 1 | Write enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| addr_i | input | ADDR_W | Byte address; top SECT_W bits select the sector |
| data_i | input | 8 | Write data / command byte |
| data_o | output | 8 | Registered read data or status byte |
| prot_i | input | 2**SECT_W | Per-sector protection, high = locked |
| vlow_i | input | 1 | Supply-low detector, high inhibits writes |

## Verification
The hardest state to reach is a paused erase that sits past its preprogram phase while a second program runs inside the pause. Only in that state do the saved erase progress, the return-to-paused path and the drop of a program aimed at the erasing sector all come into play together. The bench first programs known bytes into two sectors and starts a sector erase. It waits long enough for the zero fill to land, then issues the pause. There it reads both sectors, programs the other sector and tries to program the erasing one. It then continues the erase and checks that the final contents are correct in both sectors.

// File: rtl/flash_pkg.sv
package flash_pkg;
  typedef enum logic [2:0] {OP_IDLE, OP_PGM, OP_PRE, OP_ERS, OP_SUSP} op_st_e;
  typedef enum logic [2:0] {
    CS_READ, CS_UNL1, CS_UNL2, CS_PDATA, CS_ESET, CS_EUNL1, CS_EUNL2
  } cmd_st_e;

  localparam logic [7:0]  KEY1     = 8'hAA;
  localparam logic [7:0]  KEY2     = 8'h55;
  localparam logic [7:0]  OPC_PGM  = 8'hA0;
  localparam logic [7:0]  OPC_ESET = 8'h80;
  localparam logic [7:0]  OPC_CHIP = 8'h10;
  localparam logic [7:0]  OPC_SECT = 8'h30;
  localparam logic [7:0]  OPC_BYP  = 8'h20;
  localparam logic [7:0]  OPC_SUSP = 8'hB0;
  localparam logic [7:0]  OPC_RES  = 8'h30;
  localparam logic [7:0]  OPC_RST  = 8'hF0;
  localparam logic [10:0] ADR1     = 11'h555;
  localparam logic [10:0] ADR2     = 11'h2AA;
endpackage

// File: rtl/flash_cmd_dec.sv
module flash_cmd_dec
  import flash_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  logic [10:0] cmd_addr_i,
  input  logic [7:0]  data_i,
  input  logic        busy_i,
  input  logic        erasing_i,
  input  logic        susp_i,
  output logic        start_pgm_o,
  output logic        start_sect_o,
  output logic        start_chip_o,
  output logic        susp_req_o,
  output logic        res_req_o
);
  cmd_st_e cs, cs_n;
  logic    byp, byp_n;
  logic    a1, a2;

  assign a1 = (cmd_addr_i == ADR1);
  assign a2 = (cmd_addr_i == ADR2);

  always_comb begin
    cs_n         = cs;
    byp_n        = byp;
    start_pgm_o  = 1'b0;
    start_sect_o = 1'b0;
    start_chip_o = 1'b0;
    susp_req_o   = 1'b0;
    res_req_o    = 1'b0;
    if (wr_i) begin
      if (busy_i) begin
        if (erasing_i && data_i == OPC_SUSP) susp_req_o = 1'b1;
      end else if (data_i == OPC_RST && cs != CS_PDATA) begin
        cs_n  = CS_READ;
        byp_n = 1'b0;
      end else begin
        case (cs)
          CS_READ: begin
            if (susp_i && data_i == OPC_RES)      res_req_o = 1'b1;
            else if (byp && data_i == OPC_PGM)    cs_n = CS_PDATA;
            else if (!byp && a1 && data_i == KEY1) cs_n = CS_UNL1;
          end
          CS_UNL1: cs_n = (a2 && data_i == KEY2) ? CS_UNL2 : CS_READ;
          CS_UNL2: begin
            cs_n = CS_READ;
            if (a1) begin
              if (data_i == OPC_PGM)                   cs_n  = CS_PDATA;
              else if (data_i == OPC_ESET && !susp_i)  cs_n  = CS_ESET;
              else if (data_i == OPC_BYP && !susp_i)   byp_n = 1'b1;
            end
          end
          CS_PDATA: begin
            start_pgm_o = 1'b1;
            cs_n        = CS_READ;
          end
          CS_ESET:  cs_n = (a1 && data_i == KEY1) ? CS_EUNL1 : CS_READ;
          CS_EUNL1: cs_n = (a2 && data_i == KEY2) ? CS_EUNL2 : CS_READ;
          CS_EUNL2: begin
            cs_n = CS_READ;
            if (a1 && data_i == OPC_CHIP)  start_chip_o = 1'b1;
            else if (data_i == OPC_SECT)   start_sect_o = 1'b1;
          end
          default: cs_n = CS_READ;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs  <= CS_READ;
      byp <= 1'b0;
    end else begin
      cs  <= cs_n;
      byp <= byp_n;
    end
  end

  // R12
  busy_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && busy_i) |=> ($stable(cs) && $stable(byp)));
endmodule

// File: rtl/flash_op_eng.sv
module flash_op_eng
  import flash_pkg::*;
#(
  parameter int NSECT   = 8,
  parameter int SECT_W  = 3,
  parameter int IDX_W   = 7,
  parameter int PGM_CYC = 8,
  parameter int PRE_CYC = 16,
  parameter int ERS_CYC = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_pgm_i,
  input  logic [IDX_W-1:0] pgm_idx_i,
  input  logic [7:0]       pgm_data_i,
  input  logic             start_sect_i,
  input  logic             start_chip_i,
  input  logic [SECT_W-1:0] sect_i,
  input  logic             susp_req_i,
  input  logic             res_req_i,
  input  logic [NSECT-1:0] prot_i,
  output logic             busy_o,
  output logic             erasing_o,
  output logic             susp_o,
  output logic             pgm_en_o,
  output logic [IDX_W-1:0] pgm_idx_o,
  output logic [7:0]       pgm_data_o,
  output logic             fill_en_o,
  output logic [7:0]       fill_val_o,
  output logic [NSECT-1:0] fill_mask_o,
  output logic             poll_bit_o
);
  localparam int MAXC  = (PGM_CYC > PRE_CYC) ?
                         ((PGM_CYC > ERS_CYC) ? PGM_CYC : ERS_CYC) :
                         ((PRE_CYC > ERS_CYC) ? PRE_CYC : ERS_CYC);
  localparam int CNT_W = $clog2(MAXC + 1);

  op_st_e            st, ph;
  logic [CNT_W-1:0]  pcnt, ecnt;
  logic              ret_susp;
  logic [NSECT-1:0]  emask, emask_new, sel;
  logic [IDX_W-1:0]  p_idx;
  logic [7:0]        p_data;
  logic [SECT_W-1:0] in_sec, p_sec;

  assign in_sec    = pgm_idx_i[IDX_W-1 -: SECT_W];
  assign p_sec     = p_idx[IDX_W-1 -: SECT_W];
  assign sel       = NSECT'(1) << sect_i;
  assign emask_new = (start_chip_i ? {NSECT{1'b1}} : sel) & ~prot_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st       <= OP_IDLE;
      ph       <= OP_PRE;
      pcnt     <= '0;
      ecnt     <= '0;
      ret_susp <= 1'b0;
      emask    <= '0;
      p_idx    <= '0;
      p_data   <= '0;
    end else begin
      case (st)
        OP_IDLE: begin
          if (start_pgm_i && !prot_i[in_sec]) begin
            st       <= OP_PGM;
            pcnt     <= CNT_W'(PGM_CYC - 1);
            ret_susp <= 1'b0;
            p_idx    <= pgm_idx_i;
            p_data   <= pgm_data_i;
          end else if ((start_sect_i || start_chip_i) && |emask_new) begin
            st    <= OP_PRE;
            ecnt  <= CNT_W'(PRE_CYC - 1);
            emask <= emask_new;
          end
        end
        OP_PGM: begin
          if (pcnt == '0) st <= ret_susp ? OP_SUSP : OP_IDLE;
          else            pcnt <= pcnt - 1'b1;
        end
        OP_PRE: begin
          if (susp_req_i) begin
            st <= OP_SUSP;
            ph <= OP_PRE;
          end else if (ecnt == '0) begin
            st   <= OP_ERS;
            ecnt <= CNT_W'(ERS_CYC - 1);
          end else begin
            ecnt <= ecnt - 1'b1;
          end
        end
        OP_ERS: begin
          if (susp_req_i) begin
            st <= OP_SUSP;
            ph <= OP_ERS;
          end else if (ecnt == '0) begin
            st    <= OP_IDLE;
            emask <= '0;
          end else begin
            ecnt <= ecnt - 1'b1;
          end
        end
        OP_SUSP: begin
          if (res_req_i) begin
            st <= ph;
          end else if (start_pgm_i && !prot_i[in_sec] && !emask[in_sec]) begin
            st       <= OP_PGM;
            pcnt     <= CNT_W'(PGM_CYC - 1);
            ret_susp <= 1'b1;
            p_idx    <= pgm_idx_i;
            p_data   <= pgm_data_i;
          end
        end
        default: st <= OP_IDLE;
      endcase
    end
  end

  assign busy_o      = (st == OP_PGM) || (st == OP_PRE) || (st == OP_ERS);
  assign erasing_o   = (st == OP_PRE) || (st == OP_ERS);
  assign susp_o      = (st == OP_SUSP);
  assign pgm_en_o    = (st == OP_PGM) && (pcnt == '0);
  assign pgm_idx_o   = p_idx;
  assign pgm_data_o  = p_data;
  assign fill_en_o   = erasing_o && (ecnt == '0) && !susp_req_i;
  assign fill_val_o  = (st == OP_PRE) ? 8'h00 : 8'hFF;
  assign fill_mask_o = emask;
  assign poll_bit_o  = (st == OP_PGM) ? ~p_data[7] : 1'b0;

  // R8
  susp_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == OP_SUSP && !res_req_i) |=> ($stable(ecnt) && $stable(emask)));
  // R2
  single_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({pgm_en_o, fill_en_o}));
  // R9
  pgm_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pgm_en_o |-> !emask[p_sec]);
endmodule

// File: rtl/flash_mem.sv
module flash_mem #(
  parameter int NSECT = 8,
  parameter int OFF_W = 4,
  parameter int IDX_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pgm_en_i,
  input  logic [IDX_W-1:0] pgm_idx_i,
  input  logic [7:0]       pgm_data_i,
  input  logic             fill_en_i,
  input  logic [7:0]       fill_val_i,
  input  logic [NSECT-1:0] fill_mask_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [7:0]       rd_data_o
);
  localparam int DEPTH = 1 << OFF_W;
  localparam int N     = NSECT * DEPTH;

  logic [7:0] mem [N];

  for (genvar g = 0; g < N; g++) begin : g_byte
    localparam int SI = g / DEPTH;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mem[g] <= 8'hFF;
      end else if (fill_en_i && fill_mask_i[SI]) begin
        mem[g] <= fill_val_i;
      end else if (pgm_en_i && pgm_idx_i == IDX_W'(g)) begin
        mem[g] <= mem[g] & pgm_data_i;
      end
    end
  end

  assign rd_data_o = mem[rd_idx_i];
endmodule

// File: rtl/nor_cmd_ctrl.sv
module nor_cmd_ctrl #(
  parameter int ADDR_W  = 17,
  parameter int SECT_W  = 3,
  parameter int OFF_W   = 4,
  parameter int PGM_CYC = 8,
  parameter int PRE_CYC = 16,
  parameter int ERS_CYC = 32
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   ce_ni,
  input  logic                   we_ni,
  input  logic                   oe_ni,
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic [7:0]             data_i,
  output logic [7:0]             data_o,
  input  logic [(1<<SECT_W)-1:0] prot_i,
  input  logic                   vlow_i
);
  localparam int NSECT = 1 << SECT_W;
  localparam int IDX_W = SECT_W + OFF_W;

  logic              wr, rd, tgl;
  logic [SECT_W-1:0] sect;
  logic [IDX_W-1:0]  idx, pgm_idx;
  logic              start_pgm, start_sect, start_chip, susp_req, res_req;
  logic              busy, erasing, susp, pgm_en, fill_en, poll_bit;
  logic [7:0]        pgm_data, fill_val, rd_data;
  logic [NSECT-1:0]  fill_mask;
  logic              unused_addr;

  assign wr          = !ce_ni && !we_ni && oe_ni && !vlow_i;
  assign rd          = !ce_ni && !oe_ni && we_ni;
  assign sect        = addr_i[ADDR_W-1 -: SECT_W];
  assign idx         = {sect, addr_i[OFF_W-1:0]};
  assign unused_addr = ^addr_i;

  flash_cmd_dec u_dec (
    .clk_i, .rst_ni,
    .wr_i        (wr),
    .cmd_addr_i  (addr_i[10:0]),
    .data_i,
    .busy_i      (busy),
    .erasing_i   (erasing),
    .susp_i      (susp),
    .start_pgm_o (start_pgm),
    .start_sect_o(start_sect),
    .start_chip_o(start_chip),
    .susp_req_o  (susp_req),
    .res_req_o   (res_req)
  );

  flash_op_eng #(
    .NSECT(NSECT), .SECT_W(SECT_W), .IDX_W(IDX_W),
    .PGM_CYC(PGM_CYC), .PRE_CYC(PRE_CYC), .ERS_CYC(ERS_CYC)
  ) u_eng (
    .clk_i, .rst_ni,
    .start_pgm_i (start_pgm),
    .pgm_idx_i   (idx),
    .pgm_data_i  (data_i),
    .start_sect_i(start_sect),
    .start_chip_i(start_chip),
    .sect_i      (sect),
    .susp_req_i  (susp_req),
    .res_req_i   (res_req),
    .prot_i,
    .busy_o      (busy),
    .erasing_o   (erasing),
    .susp_o      (susp),
    .pgm_en_o    (pgm_en),
    .pgm_idx_o   (pgm_idx),
    .pgm_data_o  (pgm_data),
    .fill_en_o   (fill_en),
    .fill_val_o  (fill_val),
    .fill_mask_o (fill_mask),
    .poll_bit_o  (poll_bit)
  );

  flash_mem #(.NSECT(NSECT), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_mem (
    .clk_i, .rst_ni,
    .pgm_en_i   (pgm_en),
    .pgm_idx_i  (pgm_idx),
    .pgm_data_i (pgm_data),
    .fill_en_i  (fill_en),
    .fill_val_i (fill_val),
    .fill_mask_i(fill_mask),
    .rd_idx_i   (idx),
    .rd_data_o  (rd_data)
  );

  // status byte while busy; toggle advances per read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o <= 8'hFF;
      tgl    <= 1'b0;
    end else if (rd) begin
      if (busy) begin
        data_o <= {poll_bit, tgl, 6'b0};
        tgl    <= ~tgl;
      end else begin
        data_o <= rd_data;
      end
    end
  end

  // R11
  vlow_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vlow_i |-> !(start_pgm || start_sect || start_chip || susp_req || res_req));
  // R10
  prot_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_en |-> ((fill_mask & prot_i) == '0));
  // R5
  idle_tgl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |=> $stable(tgl));
endmodule

// File: tb/nor_cmd_ctrl_tb.sv
module nor_cmd_ctrl_tb;
  localparam int PGM_CYC = 8;
  localparam int PRE_CYC = 16;
  localparam int ERS_CYC = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [16:0] addr = '0;
  logic [7:0]  din = '0;
  logic [7:0]  dout;
  logic [7:0]  prot = '0;
  logic        vlow = 1'b0;
  int          n_run = 0, n_fail = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  nor_cmd_ctrl #(.PGM_CYC(PGM_CYC), .PRE_CYC(PRE_CYC), .ERS_CYC(ERS_CYC)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ce_ni(ce_n), .we_ni(we_n), .oe_ni(oe_n),
    .addr_i(addr), .data_i(din), .data_o(dout), .prot_i(prot), .vlow_i(vlow)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [16:0] a, input logic [7:0] d);
    @(negedge clk);
    ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1; addr = a; din = d;
    @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1;
  endtask

  task automatic bus_rd(input logic [16:0] a, output logic [7:0] d);
    @(negedge clk);
    ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; addr = a;
    @(negedge clk);
    d = dout;
    ce_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic unlock();
    bus_wr(17'h00555, 8'hAA);
    bus_wr(17'h002AA, 8'h55);
  endtask

  task automatic prog(input logic [16:0] a, input logic [7:0] d);
    unlock();
    bus_wr(17'h00555, 8'hA0);
    bus_wr(a, d);
  endtask

  task automatic erase_setup();
    unlock();
    bus_wr(17'h00555, 8'h80);
    unlock();
  endtask

  task automatic t_reset();
    logic [7:0] d;
    bus_rd(17'h00000, d); chk("R1 reset read sector0", d, 8'hFF);
    bus_rd(17'h1C00F, d); chk("R1 reset read sector7", d, 8'hFF);
  endtask

  task automatic t_program();
    logic [7:0] d1, d2;
    prog(17'h04005, 8'h5A);
    bus_rd(17'h04005, d1);
    bus_rd(17'h04005, d2);
    chk("R4 poll bit7 during program", {7'b0, d1[7]}, 8'h01);
    chk("R4 low bits zero while busy", {2'b0, d1[5:0]}, 8'h00);
    chk("R5 bit6 toggles while busy", {7'b0, d1[6] ^ d2[6]}, 8'h01);
    wait_cyc(PGM_CYC + 4);
    bus_rd(17'h04005, d1); chk("R2 programmed byte", d1, 8'h5A);
    bus_rd(17'h04005, d2); chk("R5 stable after done", d2, 8'h5A);
    prog(17'h04005, 8'h0F);
    wait_cyc(PGM_CYC + 4);
    bus_rd(17'h04005, d1); chk("R2 program ANDs old data", d1, 8'h0A);
  endtask

  task automatic t_bypass();
    logic [7:0] d;
    unlock();
    bus_wr(17'h00555, 8'h20);
    bus_wr(17'h00000, 8'hA0); bus_wr(17'h0C001, 8'h33);
    wait_cyc(PGM_CYC + 4);
    bus_rd(17'h0C001, d); chk("R3 bypass program 1", d, 8'h33);
    bus_wr(17'h00123, 8'hA0); bus_wr(17'h0C002, 8'hC3);
    wait_cyc(PGM_CYC + 4);
    bus_rd(17'h0C002, d); chk("R3 bypass program 2", d, 8'hC3);
    bus_wr(17'h00000, 8'hF0);
    bus_wr(17'h00000, 8'hA0); bus_wr(17'h0C003, 8'h00);
    wait_cyc(PGM_CYC + 4);
    bus_rd(17'h0C003, d); chk("R3 bypass exited by reset cmd", d, 8'hFF);
  endtask

  task automatic t_abort();
    logic [7:0] d;
    bus_wr(17'h00555, 8'hAA);
    bus_wr(17'h00123, 8'h55);
    bus_wr(17'h00555, 8'hA0);
    bus_wr(17'h10001, 8'h00);
    bus_rd(17'h10001, d); chk("R12 broken unlock not busy", d, 8'hFF);
    unlock();
    bus_wr(17'h00555, 8'hF0);
    bus_wr(17'h10001, 8'h00);
    wait_cyc(PGM_CYC + 4);
    bus_rd(17'h10001, d); chk("R12 reset cmd aborts sequence", d, 8'hFF);
    prog(17'h10002, 8'h44);
    unlock();
    bus_wr(17'h00555, 8'hA0);
    wait_cyc(PGM_CYC + 4);
    bus_wr(17'h10003, 8'h00);
    wait_cyc(PGM_CYC + 4);
    bus_rd(17'h10003, d); chk("R12 writes ignored while busy", d, 8'hFF);
    bus_rd(17'h10002, d); chk("R12 running program unaffected", d, 8'h44);
  endtask

  task automatic t_protect();
    logic [7:0] d;
    prot = 8'h20;
    prog(17'h14001, 8'h00);
    bus_rd(17'h14001, d); chk("R10 protected program not started", d, 8'hFF);
    wait_cyc(PGM_CYC + 4);
    bus_rd(17'h14001, d); chk("R10 protected byte unchanged", d, 8'hFF);
    prot = 8'h00;
    prog(17'h14001, 8'h3C);
    wait_cyc(PGM_CYC + 4);
    prot = 8'h20;
    erase_setup();
    bus_wr(17'h14000, 8'h30);
    bus_rd(17'h14001, d); chk("R10 protected erase not started", d, 8'h3C);
    wait_cyc(PRE_CYC + ERS_CYC + 6);
    bus_rd(17'h14001, d); chk("R10 protected sector kept", d, 8'h3C);
    prot = 8'h00;
  endtask

  task automatic t_vlow();
    logic [7:0] d;
    vlow = 1'b1;
    prog(17'h18001, 8'h00);
    vlow = 1'b0;
    bus_rd(17'h18001, d); chk("R11 inhibited program not busy", d, 8'hFF);
    wait_cyc(PGM_CYC + 4);
    bus_rd(17'h18001, d); chk("R11 inhibited byte unchanged", d, 8'hFF);
  endtask

  task automatic t_sector_erase();
    logic [7:0] d;
    prog(17'h08004, 8'h11); wait_cyc(PGM_CYC + 4);
    prog(17'h1C004, 8'h22); wait_cyc(PGM_CYC + 4);
    erase_setup();
    bus_wr(17'h08000, 8'h30);
    bus_rd(17'h08004, d); chk("R4 poll bit7 zero during erase", {7'b0, d[7]}, 8'h00);
    wait_cyc(PRE_CYC + ERS_CYC + 6);
    bus_rd(17'h08004, d); chk("R6 erased byte", d, 8'hFF);
    bus_rd(17'h1C004, d); chk("R6 other sector kept", d, 8'h22);
  endtask

  task automatic t_suspend();
    logic [7:0] d;
    prog(17'h08005, 8'h66); wait_cyc(PGM_CYC + 4);
    prog(17'h04006, 8'h77); wait_cyc(PGM_CYC + 4);
    erase_setup();
    bus_wr(17'h08000, 8'h30);
    wait_cyc(PRE_CYC + 8);
    bus_wr(17'h00000, 8'hB0);
    bus_rd(17'h08005, d); chk("R6 preprogram to zero seen in pause", d, 8'h00);
    bus_rd(17'h04006, d); chk("R8 other sector readable in pause", d, 8'h77);
    prog(17'h04007, 8'h0F);
    wait_cyc(PGM_CYC + 4);
    bus_rd(17'h04007, d); chk("R9 program during pause", d, 8'h0F);
    bus_rd(17'h08005, d); chk("R9 erase stays paused", d, 8'h00);
    prog(17'h08006, 8'h12);
    bus_rd(17'h08006, d); chk("R9 program to erasing sector dropped", d, 8'h00);
    bus_wr(17'h00000, 8'h30);
    bus_rd(17'h08005, d); chk("R8 resumed erase busy", {d[7], 7'b0}, 8'h00);
    wait_cyc(ERS_CYC + 6);
    bus_rd(17'h08005, d); chk("R8 erase completes after resume", d, 8'hFF);
    bus_rd(17'h08006, d); chk("R8 whole sector erased", d, 8'hFF);
    bus_rd(17'h04007, d); chk("R9 paused-program byte kept", d, 8'h0F);
  endtask

  task automatic t_chip();
    logic [7:0] d;
    prog(17'h00008, 8'h12); wait_cyc(PGM_CYC + 4);
    prog(17'h1C008, 8'h34); wait_cyc(PGM_CYC + 4);
    prot = 8'h01;
    erase_setup();
    bus_wr(17'h00555, 8'h10);
    wait_cyc(PRE_CYC + ERS_CYC + 6);
    bus_rd(17'h1C008, d); chk("R7 chip erase clears sector7", d, 8'hFF);
    bus_rd(17'h04005, d); chk("R7 chip erase clears sector1", d, 8'hFF);
    bus_rd(17'h00008, d); chk("R10 chip erase skips protected", d, 8'h12);
    prot = 8'h00;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_program();
    t_bypass();
    t_abort();
    t_protect();
    t_vlow();
    t_sector_erase();
    t_suspend();
    t_chip();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule